// File: doc/BRIEF.md
# Row Pooling, Shift and Channel-Shuffle Writeback Stage

This stage sits between a convolution array and the memory write port of a layer-at-a-time feature-map accelerator. Each cycle it may accept one row of 4-bit activations. The row holds `W` pixels and belongs to a single channel. The stage can reduce the row with a 2x2, stride-2 max pool. It can then displace the result by one pixel in one of four directions, or leave it where it is. It also computes the memory address where the processed row lands.

Horizontal displacement is done inside the row vector. Vertical displacement is done by moving the destination row in the address. The channel shuffle is a circular rotation of the channel index, applied only to the address. Rows of one channel arrive in increasing row order. While pooling is on, even rows are kept in a one-row store and produce no output. Each odd row then produces a complete pooled row of `W/2` pixels in a single cycle. The pooled row sits in the low half of the output vector.

Top module: `rpsw_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `out_valid` is 0.
- R2: With `pool_en`=0 and `shift_mode`=0 (identity), an accepted row appears unchanged on `out_data`, with `out_valid`=1, exactly one clock after it is accepted.
- R3: `shift_mode`=1 (left) gives output lane i = lane i+1 of the working row. The highest working lane becomes 0.
- R4: `shift_mode`=2 (right) gives output lane i = lane i-1 of the working row. Lane 0 becomes 0.
- R5: With `pool_en`=1, a row with even `in_row` is stored and produces no output. A row with odd `in_row` produces lane j (j < W/2) = the maximum of lanes 2j and 2j+1 of both the stored row and the current row. Its output row index is `in_row`/2. Lane k means bits [k*DW +: DW].
- R6: With pooling on, the working row is W/2 lanes wide. Left and right shifts act within those lanes, and lanes W/2 and above are always 0.
- R7: `shift_mode`=3 (up) writes to output row index minus one. A row whose output index is 0 is dropped, so `out_valid` stays 0.
- R8: `shift_mode`=4 (down) writes to output row index plus one. A row whose output index is the last one (ROWS-1, or ROWS/2-1 with pooling) is dropped.
- R9: `out_addr` = `base_addr` + dest_row*ROW_STRIDE + ((`in_chan` + `shuf_off`) mod CH_TOTAL)*CH_STRIDE, truncated to AW bits. Both `in_chan` and `shuf_off` are below CH_TOTAL.
- R10: `shift_mode` codes 5 to 7 act as identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row is presented this cycle |
| in_data | input | W*DW | Row of W pixels, lane k at bits [k*DW +: DW] |
| in_row | input | $clog2(ROWS) | Row index of the input row within the image |
| in_chan | input | $clog2(CH_TOTAL) | Channel of the input row |
| pool_en | input | 1 | Enable 2x2 stride-2 max pooling |
| shift_mode | input | 3 | 0 identity, 1 left, 2 right, 3 up, 4 down |
| shuf_off | input | $clog2(CH_TOTAL) | Circular channel rotation amount |
| base_addr | input | AW | Layer output base address |
| out_valid | output | 1 | Write strobe for the processed row |
| out_data | output | W*DW | Processed row |
| out_addr | output | AW | Destination address |

## Verification
The hardest situations to reach combine pooling with the edge cases. One is an up shift on the first pooled row, whose input row is 1 and not 0. Another is a down shift on input row ROWS-1, which folds onto the last pooled row. A third is channel plus offset wrapping past a channel count that is not a power of two. The stimulus walks every shift code over whole eight-row images twice, with pooling off and then on. Channel and offset are chosen per pass so that several passes wrap. Idle cycles are placed between rows, which shows that the stored row survives gaps. The behavioural model is compared against the block on every clock.

// File: rtl/rpsw_pkg.sv
package rpsw_pkg;

    typedef enum logic [2:0] {
        SH_NONE  = 3'd0,
        SH_LEFT  = 3'd1,
        SH_RIGHT = 3'd2,
        SH_UP    = 3'd3,
        SH_DOWN  = 3'd4
    } shift_e;

    typedef struct packed {
        logic   pool;
        shift_e shift;
    } mode_t;

endpackage

// File: rtl/rpsw_row_pool.sv
module rpsw_row_pool #(
    parameter int W  = 8,
    parameter int DW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            pool_en,
    input  logic            row_odd,
    input  logic [W*DW-1:0] in_data,
    output logic [W*DW-1:0] work_row
);
    localparam int HALF = W / 2;

    logic [W*DW-1:0] prev_q;
    logic [W*DW-1:0] pooled;

    function automatic logic [DW-1:0] vmax(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else if (in_valid && pool_en && !row_odd)
            prev_q <= in_data;
    end

    for (genvar j = 0; j < W; j++) begin : g_lane
        if (j < HALF) begin : g_pool
            assign pooled[j*DW +: DW] =
                vmax(vmax(prev_q[(2*j)*DW +: DW], prev_q[(2*j+1)*DW +: DW]),
                     vmax(in_data[(2*j)*DW +: DW], in_data[(2*j+1)*DW +: DW]));
        end else begin : g_zero
            assign pooled[j*DW +: DW] = '0;
        end
    end

    assign work_row = pool_en ? pooled : in_data;

endmodule

// File: rtl/rpsw_row_shift.sv
module rpsw_row_shift
    import rpsw_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 4
) (
    input  mode_t           mode,
    input  logic [W*DW-1:0] din,
    output logic [W*DW-1:0] dout
);
    localparam int HALF = W / 2;

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic [DW-1:0] nxt, prv, cur;
        logic          in_rng, nxt_ok, prv_ok;

        if (i < W - 1) begin : g_n
            assign nxt = din[(i+1)*DW +: DW];
        end else begin : g_nz
            assign nxt = '0;
        end
        if (i > 0) begin : g_p
            assign prv = din[(i-1)*DW +: DW];
        end else begin : g_pz
            assign prv = '0;
        end
        assign cur    = din[i*DW +: DW];
        assign in_rng = mode.pool ? (i < HALF) : 1'b1;
        assign nxt_ok = mode.pool ? (i + 1 < HALF) : (i + 1 < W);
        assign prv_ok = (i > 0) && in_rng;

        always_comb begin
            case (mode.shift)
                SH_LEFT:  dout[i*DW +: DW] = nxt_ok ? nxt : '0;
                SH_RIGHT: dout[i*DW +: DW] = prv_ok ? prv : '0;
                default:  dout[i*DW +: DW] = in_rng ? cur : '0;
            endcase
        end
    end

endmodule

// File: rtl/rpsw_wb_addr.sv
module rpsw_wb_addr
    import rpsw_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int CH_TOTAL   = 6,
    parameter int ROW_STRIDE = 4,
    parameter int CH_STRIDE  = 64,
    parameter int AW         = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(CH_TOTAL)
) (
    input  mode_t          mode,
    input  logic [RW-1:0]  row_idx,
    input  logic [CW-1:0]  chan,
    input  logic [CW-1:0]  offset,
    input  logic [AW-1:0]  base,
    output logic [AW-1:0]  addr,
    output logic           drop
);
    logic [RW-1:0] orow, last_row, dst;
    logic [CW:0]   sum;
    logic [CW-1:0] shuf;

    always_comb begin
        orow     = mode.pool ? (row_idx >> 1) : row_idx;
        last_row = mode.pool ? RW'(ROWS / 2 - 1) : RW'(ROWS - 1);
        drop     = 1'b0;
        dst      = orow;
        case (mode.shift)
            SH_UP: begin
                if (orow == '0) drop = 1'b1;
                else            dst  = orow - 1'b1;
            end
            SH_DOWN: begin
                if (orow == last_row) drop = 1'b1;
                else                  dst  = orow + 1'b1;
            end
            default: ;
        endcase
        sum  = {1'b0, chan} + {1'b0, offset};
        shuf = (sum >= (CW+1)'(CH_TOTAL)) ? CW'(sum - (CW+1)'(CH_TOTAL)) : sum[CW-1:0];
        addr = base + AW'(dst) * AW'(ROW_STRIDE) + AW'(shuf) * AW'(CH_STRIDE);
    end

endmodule

// File: rtl/rpsw_top.sv
module rpsw_top
    import rpsw_pkg::*;
#(
    parameter int W          = 8,
    parameter int DW         = 4,
    parameter int ROWS       = 8,
    parameter int CH_TOTAL   = 6,
    parameter int ROW_STRIDE = 4,
    parameter int CH_STRIDE  = 64,
    parameter int AW         = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(CH_TOTAL)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [W*DW-1:0] in_data,
    input  logic [RW-1:0]   in_row,
    input  logic [CW-1:0]   in_chan,
    input  logic            pool_en,
    input  logic [2:0]      shift_mode,
    input  logic [CW-1:0]   shuf_off,
    input  logic [AW-1:0]   base_addr,
    output logic            out_valid,
    output logic [W*DW-1:0] out_data,
    output logic [AW-1:0]   out_addr
);
    mode_t           mode;
    logic [W*DW-1:0] work_row, shifted;
    logic [AW-1:0]   wb_addr;
    logic            drop, emit;

    assign mode.pool  = pool_en;
    assign mode.shift = shift_e'(shift_mode);

    rpsw_row_pool #(.W(W), .DW(DW)) u_pool (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pool_en(pool_en),
        .row_odd(in_row[0]), .in_data(in_data), .work_row(work_row)
    );

    rpsw_row_shift #(.W(W), .DW(DW)) u_shift (
        .mode(mode), .din(work_row), .dout(shifted)
    );

    rpsw_wb_addr #(
        .ROWS(ROWS), .CH_TOTAL(CH_TOTAL), .ROW_STRIDE(ROW_STRIDE),
        .CH_STRIDE(CH_STRIDE), .AW(AW)
    ) u_addr (
        .mode(mode), .row_idx(in_row), .chan(in_chan), .offset(shuf_off),
        .base(base_addr), .addr(wb_addr), .drop(drop)
    );

    assign emit = in_valid && !drop && (!pool_en || in_row[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data <= shifted;
                out_addr <= wb_addr;
            end
        end
    end

endmodule

// File: rtl/rpsw_checker.sv
module rpsw_checker #(
    parameter int W    = 8,
    parameter int DW   = 4,
    parameter int ROWS = 8,
    parameter int RW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [W*DW-1:0] in_data,
    input logic [RW-1:0]   in_row,
    input logic            pool_en,
    input logic [2:0]      shift_mode,
    input logic            out_valid,
    input logic [W*DW-1:0] out_data
);
    localparam int HB = W * DW / 2;

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pool_en && shift_mode == 3'd0) |=> (out_valid && out_data == $past(in_data)));

    a_r3_left_top_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pool_en && shift_mode == 3'd1) |=> (out_data[W*DW-1 -: DW] == '0));

    a_r5_even_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pool_en && !in_row[0]) |=> !out_valid);

    a_r6_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pool_en && in_row[0]) |=> (out_data[W*DW-1 -: HB] == '0));

    a_r7_top_drop: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pool_en && shift_mode == 3'd3 && in_row == '0) |=> !out_valid);

    a_r8_bottom_drop: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pool_en && shift_mode == 3'd4 && in_row == RW'(ROWS - 1)) |=> !out_valid);

endmodule

bind rpsw_top rpsw_checker #(.W(W), .DW(DW), .ROWS(ROWS), .RW(RW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_row(in_row),
    .pool_en(pool_en), .shift_mode(shift_mode), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/rpsw_top_test.sv
module rpsw_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8, DW = 4, ROWS = 8, CH_TOTAL = 6;
    localparam int ROW_STRIDE = 4, CH_STRIDE = 64, AW = 16;
    localparam int RW = $clog2(ROWS), CW = $clog2(CH_TOTAL);

    logic clk = 0, rst = 1;
    logic in_valid = 0, pool_en = 0;
    logic [W*DW-1:0] in_data = '0;
    logic [RW-1:0] in_row = '0;
    logic [CW-1:0] in_chan = '0, shuf_off = '0;
    logic [2:0] shift_mode = '0;
    logic [AW-1:0] base_addr = '0;
    logic out_valid;
    logic [W*DW-1:0] out_data;
    logic [AW-1:0] out_addr;

    int checks = 0, fails = 0, cycles = 0;
    logic exp_valid;
    logic [W*DW-1:0] exp_data, prev_m;
    logic [AW-1:0] exp_addr;
    int exp_mode, exp_pool;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpsw_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_row(in_row),
        .in_chan(in_chan), .pool_en(pool_en), .shift_mode(shift_mode), .shuf_off(shuf_off),
        .base_addr(base_addr), .out_valid(out_valid), .out_data(out_data), .out_addr(out_addr)
    );

    function automatic string tag(int pool, int mode);
        if (pool != 0 && (mode == 1 || mode == 2)) return "R6";
        if (mode == 3) return "R7";
        if (mode == 4) return "R8";
        if (pool != 0) return "R5";
        if (mode == 1) return "R3";
        if (mode == 2) return "R4";
        if (mode >= 5) return "R10";
        return "R2";
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        int n, orow, lastr, dst, a, b, c, d;
        int p[W];
        int q[W];
        logic emit;
        logic [W*DW-1:0] v;
        if (rst) begin
            exp_valid <= 0; exp_data <= '0; exp_addr <= '0; prev_m <= '0;
        end else begin
            exp_valid <= 0;
            if (in_valid) begin
                n = pool_en ? W/2 : W;
                emit = 1;
                if (pool_en && !in_row[0]) begin
                    prev_m <= in_data;
                    emit = 0;
                end
                for (int i = 0; i < W; i++) begin
                    if (pool_en) begin
                        if (i < W/2) begin
                            a = int'(prev_m[(2*i)*DW +: DW]);   b = int'(prev_m[(2*i+1)*DW +: DW]);
                            c = int'(in_data[(2*i)*DW +: DW]);  d = int'(in_data[(2*i+1)*DW +: DW]);
                            if (b > a) a = b;
                            if (c > a) a = c;
                            if (d > a) a = d;
                            p[i] = a;
                        end else p[i] = 0;
                    end else p[i] = int'(in_data[i*DW +: DW]);
                end
                for (int i = 0; i < W; i++) begin
                    if (shift_mode == 3'd1)      q[i] = (i + 1 < n) ? p[i+1] : 0;
                    else if (shift_mode == 3'd2) q[i] = (i >= 1 && i < n) ? p[i-1] : 0;
                    else                         q[i] = (i < n) ? p[i] : 0;
                end
                orow  = pool_en ? int'(in_row) / 2 : int'(in_row);
                lastr = pool_en ? ROWS/2 - 1 : ROWS - 1;
                dst = orow;
                if (shift_mode == 3'd3) begin
                    if (orow == 0) emit = 0; else dst = orow - 1;
                end else if (shift_mode == 3'd4) begin
                    if (orow == lastr) emit = 0; else dst = orow + 1;
                end
                for (int i = 0; i < W; i++) v[i*DW +: DW] = DW'(q[i]);
                if (emit) begin
                    exp_valid <= 1;
                    exp_data  <= v;
                    exp_addr  <= AW'(int'(base_addr) + dst*ROW_STRIDE
                                 + ((int'(in_chan) + int'(shuf_off)) % CH_TOTAL) * CH_STRIDE);
                    exp_mode  <= int'(shift_mode);
                    exp_pool  <= int'(pool_en);
                end
            end
        end
    end

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid) begin
            fails++;
            $display("FAIL %s valid: actual %0b expected %0b", tag(exp_pool, exp_mode), out_valid, exp_valid);
        end
        if (exp_valid) begin
            checks++;
            if (out_data !== exp_data) begin
                fails++;
                $display("FAIL %s data: actual %h expected %h", tag(exp_pool, exp_mode), out_data, exp_data);
            end
            checks++;
            if (out_addr !== exp_addr) begin
                fails++;
                $display("FAIL R9 addr: actual %h expected %h", out_addr, exp_addr);
            end
        end
    endtask

    task automatic step(input logic v, input int row, input int ch, input int pool,
                        input int mode, input int off, input int base);
        @(negedge clk);
        compare();
        in_valid   = v;
        in_data    = (W*DW)'($urandom());
        in_row     = RW'(row);
        in_chan    = CW'(ch);
        pool_en    = (pool != 0);
        shift_mode = 3'(mode);
        shuf_off   = CW'(off);
        base_addr  = AW'(base);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below 20000", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual %0b expected 0", out_valid);
        end
        rst = 0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: actual %0b expected 0", out_valid);
        end
        for (int pool = 0; pool < 2; pool++) begin
            for (int mode = 0; mode < 8; mode++) begin
                for (int r = 0; r < ROWS; r++) begin
                    step(1'b1, r, (mode*2 + pool) % CH_TOTAL, pool, mode,
                         (mode + 3*pool + 1) % CH_TOTAL, 16'h1000 + mode*16'h0100);
                    if (r == 4) step(1'b0, 0, 0, pool, 0, 0, 0);
                end
                step(1'b0, 0, 0, 0, 0, 0, 0);
            end
        end
        // R9: maximal channel wrap
        for (int r = 0; r < 4; r++) step(1'b1, r, CH_TOTAL-1, 0, 0, CH_TOTAL-1, 16'hFFF0);
        for (int k = 0; k < 3; k++) step(1'b0, 0, 0, 0, 0, 0, 0);
        report();
    end
endmodule